// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor data port and a slower word-wide memory bus, and neither side needs to know it is there. Every cacheable address maps to exactly one line. A read or write that hits is served from local storage. A miss first writes the old line back if it is dirty, then fetches the new line one word at a time, and then completes from the cache. Writes update only the cache and mark the line dirty, and a write miss allocates the line before it merges the write.

Addresses in the top sixteenth of the address space are reserved for memory-mapped peripherals. Accesses there skip the cache and go to the bus as a single transfer. A separate fence handshake makes the cache write every dirty line back to memory and invalidate all lines, so later accesses fetch fresh data from memory. Line size and line count are parameters, and both must be powers of two.

Top module: `dcache_wb`

## Requirements
- R1: After reset is released, cpu_ack_o, bus_req_o and fence_done_o are low and every line is invalid, so the first cacheable access is a miss.
- R2: The line index is address bits [OFF_W +: log2(NUM_BLOCKS)], where OFF_W = log2(BLOCK_BYTES). Two cacheable addresses with the same index but different upper bits evict each other.
- R3: A read hit raises cpu_ack_o, with cpu_rdata_o valid, in the cycle after the request is first presented. It makes no bus transfer, and cpu_ack_o is never high without a request.
- R4: A write hit changes only the byte lanes i with cpu_be_i[i]=1 (data bits 8i+7..8i) and makes no bus transfer.
- R5: A miss on an invalid or clean line reads BLOCK_BYTES/4 words from the bus, in ascending address order from the line base, with bus_be_o=4'hF. The access then completes from the cache.
- R6: A write miss allocates the line (line fill) and then merges the write into it, without writing to the bus.
- R7: A miss on a dirty line first writes all BLOCK_BYTES/4 words of the old line to their own addresses, in ascending order, and then fills the new line.
- R8: An access with cpu_addr_i[31:28]=4'hF makes exactly one bus transfer with the CPU's address, write flag, data and byte enables. It leaves the cache contents unchanged.
- R9: While fence_i is held, the cache writes back every dirty line, invalidates all lines and pulses fence_done_o for one cycle. A fence has priority over CPU requests, and no CPU request is acknowledged before fence_done_o.
- R10: A bus error on a line fill or an uncached transfer ends the CPU access with cpu_ack_o and cpu_err_o both high. After a fill error the line stays invalid.
- R11: On the bus, bus_req_o stays high with a stable bus_addr_o until bus_ack_i or bus_err_i. After each response bus_req_o is low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU request, held until acknowledged |
| cpu_we_i | input | 1 | CPU write when high |
| cpu_addr_i | input | 32 | CPU byte address |
| cpu_wdata_i | input | 32 | CPU write data |
| cpu_be_i | input | 4 | CPU byte enables |
| cpu_rdata_o | output | 32 | Read data, valid with cpu_ack_o |
| cpu_ack_o | output | 1 | One-cycle access completion |
| cpu_err_o | output | 1 | Bus error for the completing access |
| fence_i | input | 1 | Fence request, held until fence_done_o |
| fence_done_o | output | 1 | One-cycle fence completion |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | Bus write when high |
| bus_addr_o | output | 32 | Bus byte address (word aligned for line traffic) |
| bus_wdata_o | output | 32 | Bus write data |
| bus_be_o | output | 4 | Bus byte enables |
| bus_rdata_i | input | 32 | Bus read data |
| bus_ack_i | input | 1 | Bus transfer complete |
| bus_err_i | input | 1 | Bus transfer failed |

## Verification
A corrupted valid bit or tag shows up at the ports on the next access to that line. The bus read count is then wrong: a false miss fetches a line that was already present, and a false hit makes no transfer. The data may also be wrong. A lost dirty bit stays hidden until that line is evicted or fenced, and then the write-back count and the memory contents both fall short. A shadow model of the line states predicts the exact bus read and write counts and the data for every access, and after each fence memory is compared word for word with the expected image.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_WB, ST_FILL, ST_UNC, ST_SCAN, ST_INV} dc_state_e;

  localparam logic [3:0] UNC_NIBBLE = 4'hF;

  function automatic logic is_uncached(input logic [31:0] a);
    return a[31:28] == UNC_NIBBLE;
  endfunction
endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store #(
  parameter int NUM_BLOCKS = 4,
  parameter int IDX_W      = 2,
  parameter int TAG_W      = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic             rd_dirty_o,
  output logic [TAG_W-1:0] rd_tag_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_valid_i,
  input  logic             wr_dirty_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             clr_all_i
);
  logic [NUM_BLOCKS-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0]      tag_q [NUM_BLOCKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < NUM_BLOCKS; i++) tag_q[i] <= '0;
    end else if (clr_all_i) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= wr_valid_i;
      dirty_q[wr_idx_i] <= wr_dirty_i;
      tag_q[wr_idx_i]   <= wr_tag_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_dirty_o = dirty_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
endmodule

// File: rtl/dcache_data_store.sv
module dcache_data_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [31:0]   rd_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [3:0]    wr_be_i,
  input  logic [31:0]   wr_data_i
);
  logic [31:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int b = 0; b < 4; b++)
        if (wr_be_i[b]) mem_q[wr_addr_i][8*b +: 8] <= wr_data_i[8*b +: 8];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/dcache_wb.sv
module dcache_wb
  import dcache_pkg::*;
#(
  parameter int BLOCK_BYTES = 16,
  parameter int NUM_BLOCKS  = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cpu_req_i,
  input  logic        cpu_we_i,
  input  logic [31:0] cpu_addr_i,
  input  logic [31:0] cpu_wdata_i,
  input  logic [3:0]  cpu_be_i,
  output logic [31:0] cpu_rdata_o,
  output logic        cpu_ack_o,
  output logic        cpu_err_o,
  input  logic        fence_i,
  output logic        fence_done_o,
  output logic        bus_req_o,
  output logic        bus_we_o,
  output logic [31:0] bus_addr_o,
  output logic [31:0] bus_wdata_o,
  output logic [3:0]  bus_be_o,
  input  logic [31:0] bus_rdata_i,
  input  logic        bus_ack_i,
  input  logic        bus_err_i
);
  localparam int WPL   = BLOCK_BYTES / 4;
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDXB  = $clog2(NUM_BLOCKS);
  localparam int IDX_W = (IDXB > 0) ? IDXB : 1;
  localparam int TAG_W = 32 - OFF_W;
  localparam int DEPTH = NUM_BLOCKS * WPL;
  localparam int DA_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(WPL) + 1;

  function automatic logic [DA_W-1:0] dptr(input logic [IDX_W-1:0] i, input logic [CNT_W-1:0] w);
    return DA_W'(32'(i) * 32'(WPL) + 32'(w));
  endfunction

  dc_state_e        st_q;
  logic [IDX_W-1:0] line_q;
  logic [CNT_W-1:0] cnt_q;
  logic             gap_q, ack_q, err_q, done_q, in_fence_q;
  logic [31:0]      rdata_q;

  logic [IDX_W-1:0] cpu_idx, ts_idx, ts_widx;
  logic [CNT_W-1:0] cpu_word;
  logic [TAG_W-1:0] cpu_tag, ts_tag, ts_wtag;
  logic             ts_valid, ts_dirty, ts_we, ts_wvalid, ts_wdirty, ts_clr;
  logic [31:0]      ds_rdata;
  logic             ds_we;
  logic [DA_W-1:0]  ds_waddr;
  logic [3:0]       ds_wbe;
  logic [31:0]      ds_wdata;

  logic idle, hit, fence_go, cpu_go, unc, bus_done, last_word, last_line;

  assign cpu_idx   = IDX_W'((cpu_addr_i >> OFF_W) % 32'(NUM_BLOCKS));
  assign cpu_word  = CNT_W'((cpu_addr_i >> 2) % 32'(WPL));
  assign cpu_tag   = cpu_addr_i[31:OFF_W];
  assign idle      = (st_q == ST_IDLE);
  assign ts_idx    = idle ? cpu_idx : line_q;
  assign hit       = ts_valid && (ts_tag == cpu_tag);
  assign fence_go  = idle && fence_i && !done_q;
  assign cpu_go    = idle && cpu_req_i && !ack_q && !fence_go;
  assign unc       = is_uncached(cpu_addr_i);
  assign bus_done  = bus_req_o && (bus_ack_i || bus_err_i);
  assign last_word = (cnt_q == CNT_W'(WPL - 1));
  assign last_line = (line_q == IDX_W'(NUM_BLOCKS - 1));

  dcache_tag_store #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .rd_idx_i(ts_idx), .rd_valid_o(ts_valid), .rd_dirty_o(ts_dirty), .rd_tag_o(ts_tag),
    .wr_en_i(ts_we), .wr_idx_i(ts_widx), .wr_valid_i(ts_wvalid), .wr_dirty_i(ts_wdirty),
    .wr_tag_i(ts_wtag), .clr_all_i(ts_clr)
  );

  dcache_data_store #(.DEPTH(DEPTH), .AW(DA_W)) u_data (
    .clk_i,
    .rd_addr_i(idle ? dptr(cpu_idx, cpu_word) : dptr(line_q, cnt_q)), .rd_data_o(ds_rdata),
    .wr_en_i(ds_we), .wr_addr_i(ds_waddr), .wr_be_i(ds_wbe), .wr_data_i(ds_wdata)
  );

  // tag and data store update requests
  always_comb begin
    ts_we = 1'b0; ts_widx = line_q; ts_wvalid = 1'b0; ts_wdirty = 1'b0; ts_wtag = ts_tag;
    ts_clr = (st_q == ST_INV);
    ds_we = 1'b0; ds_waddr = dptr(line_q, cnt_q); ds_wbe = 4'hF; ds_wdata = bus_rdata_i;
    if (cpu_go && !unc) begin
      if (hit && cpu_we_i) begin
        ts_we = 1'b1; ts_widx = cpu_idx; ts_wvalid = 1'b1; ts_wdirty = 1'b1; ts_wtag = cpu_tag;
        ds_we = 1'b1; ds_waddr = dptr(cpu_idx, cpu_word); ds_wbe = cpu_be_i; ds_wdata = cpu_wdata_i;
      end else if (!hit && !(ts_valid && ts_dirty)) begin
        ts_we = 1'b1; ts_widx = cpu_idx; ts_wtag = cpu_tag;  // invalid until fill completes
      end
    end
    if (st_q == ST_WB && bus_done && last_word && (!bus_err_i || in_fence_q)) ts_we = 1'b1;
    if (st_q == ST_FILL && bus_done && !bus_err_i) begin
      ds_we = 1'b1;
      if (last_word) begin
        ts_we = 1'b1; ts_wvalid = 1'b1; ts_wtag = cpu_tag;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; line_q <= '0; cnt_q <= '0; gap_q <= 1'b0; ack_q <= 1'b0;
      err_q <= 1'b0; done_q <= 1'b0; in_fence_q <= 1'b0; rdata_q <= '0;
    end else begin
      ack_q  <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      gap_q  <= bus_done;
      case (st_q)
        ST_IDLE: begin
          if (fence_go) begin
            in_fence_q <= 1'b1; line_q <= '0; st_q <= ST_SCAN;
          end else if (cpu_go) begin
            if (unc) st_q <= ST_UNC;
            else if (hit) begin
              ack_q <= 1'b1; rdata_q <= ds_rdata;
            end else begin
              line_q <= cpu_idx; cnt_q <= '0;
              st_q   <= (ts_valid && ts_dirty) ? ST_WB : ST_FILL;
            end
          end
        end
        ST_SCAN: begin
          if (ts_valid && ts_dirty) begin
            cnt_q <= '0; st_q <= ST_WB;
          end else if (last_line) st_q <= ST_INV;
          else line_q <= line_q + IDX_W'(1);
        end
        ST_WB: if (bus_done) begin
          if (bus_err_i && !in_fence_q) begin
            ack_q <= 1'b1; err_q <= 1'b1; st_q <= ST_IDLE;
          end else if (last_word) begin
            cnt_q <= '0;
            if (!in_fence_q) st_q <= ST_FILL;
            else if (last_line) st_q <= ST_INV;
            else begin
              line_q <= line_q + IDX_W'(1); st_q <= ST_SCAN;
            end
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_FILL: if (bus_done) begin
          if (bus_err_i) begin
            ack_q <= 1'b1; err_q <= 1'b1; st_q <= ST_IDLE;
          end else if (last_word) st_q <= ST_IDLE;  // re-lookup now hits
          else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_UNC: if (bus_done) begin
          ack_q <= 1'b1; err_q <= bus_err_i; rdata_q <= bus_rdata_i; st_q <= ST_IDLE;
        end
        ST_INV: begin
          done_q <= 1'b1; in_fence_q <= 1'b0; st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_o   = (st_q == ST_WB || st_q == ST_FILL || st_q == ST_UNC) && !gap_q;
  assign bus_we_o    = (st_q == ST_WB) || (st_q == ST_UNC && cpu_we_i);
  assign bus_wdata_o = (st_q == ST_UNC) ? cpu_wdata_i : ds_rdata;
  assign bus_be_o    = (st_q == ST_UNC) ? cpu_be_i : 4'hF;
  always_comb begin
    case (st_q)
      ST_WB:   bus_addr_o = {ts_tag, {OFF_W{1'b0}}} | (32'(cnt_q) << 2);
      ST_FILL: bus_addr_o = {cpu_tag, {OFF_W{1'b0}}} | (32'(cnt_q) << 2);
      ST_UNC:  bus_addr_o = cpu_addr_i;
      default: bus_addr_o = '0;
    endcase
  end

  assign cpu_ack_o    = ack_q;
  assign cpu_err_o    = err_q;
  assign cpu_rdata_o  = rdata_q;
  assign fence_done_o = done_q;

  // R11: request held with stable address until a response
  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i && !bus_err_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));
  // R11: one idle cycle after every response
  a_r11_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_done |=> !bus_req_o);
  a_r3_ack_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |-> cpu_req_i);
  a_r10_err_with_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_err_o |-> cpu_ack_o);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_done_o |=> !fence_done_o);
  a_r9_no_ack_in_fence: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fence_q |-> !cpu_ack_o);
  a_r8_unc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_UNC && bus_done) |=> (st_q == ST_IDLE && cpu_ack_o));
endmodule

// File: tb/tb_dcache_wb.sv
`timescale 1ns/1ps
module tb_dcache_wb;
  localparam int BB = 16, NB = 4, WPL = BB / 4, LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0, fence = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic [3:0] cpu_be = 0;
  logic [31:0] cpu_rdata, bus_addr, bus_wdata;
  logic cpu_ack, cpu_err, fence_done, bus_req, bus_we;
  logic [3:0] bus_be;
  logic [31:0] bus_rdata = 0;
  logic bus_ack = 0, bus_err = 0;

  always #2 clk = ~clk;

  dcache_wb #(.BLOCK_BYTES(BB), .NUM_BLOCKS(NB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_be_i(cpu_be), .cpu_rdata_o(cpu_rdata), .cpu_ack_o(cpu_ack),
    .cpu_err_o(cpu_err), .fence_i(fence), .fence_done_o(fence_done), .bus_req_o(bus_req),
    .bus_we_o(bus_we), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_be_o(bus_be),
    .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack), .bus_err_i(bus_err)
  );

  int nchk = 0, nerr = 0;
  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // memory images: slave (main memory) and expected CPU view
  logic [31:0] smem [int unsigned];
  logic [31:0] gmem [int unsigned];
  function automatic logic [31:0] seedv(input logic [31:0] a);
    return {a[17:2], ~a[17:2]};
  endfunction
  function automatic logic [31:0] s_rd(input logic [31:0] a);
    return smem.exists(int'(a[31:2])) ? smem[int'(a[31:2])] : seedv(a);
  endfunction
  function automatic logic [31:0] g_rd(input logic [31:0] a);
    return gmem.exists(int'(a[31:2])) ? gmem[int'(a[31:2])] : seedv(a);
  endfunction
  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  // bus slave
  int n_rd = 0, n_wr = 0, lat_c = 0;
  logic [31:0] baddr_q [$];
  logic [3:0] bbe_q [$];
  logic [31:0] err_addr = 0;
  bit err_arm = 0;
  always @(negedge clk) begin
    if (bus_ack || bus_err) begin
      bus_ack = 0; bus_err = 0;
    end else if (bus_req) begin
      if (lat_c < LAT) lat_c++;
      else begin
        lat_c = 0;
        baddr_q.push_back(bus_addr);
        bbe_q.push_back(bus_be);
        if (err_arm && bus_addr == err_addr) begin
          bus_err = 1; bus_rdata = 32'hDEAD_BEEF;
        end else begin
          bus_ack = 1;
          if (bus_we) begin
            n_wr++; smem[int'(bus_addr[31:2])] = mrg(s_rd(bus_addr), bus_wdata, bus_be);
          end else begin
            n_rd++; bus_rdata = s_rd(bus_addr);
          end
        end
      end
    end
  end

  // per-clock protocol monitor, sampled after the edge
  bit cpu_busy = 0, fence_busy = 0, prev_req = 0;
  logic [31:0] prev_addr = 0;
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (cpu_ack && !cpu_busy) chk("R3 ack without request", 1, 0);
      if (fence_done && !fence_busy) chk("R9 done without fence", 1, 0);
      if (prev_req && !(bus_ack || bus_err)) begin
        chk("R11 request held", {31'b0, bus_req}, 1);
        chk("R11 address stable", bus_addr, prev_addr);
      end else if (prev_req) chk("R11 gap after response", {31'b0, bus_req}, 0);
    end
    prev_req = bus_req; prev_addr = bus_addr;
  end

  task automatic cpu_xfer(input logic we, input logic [31:0] a, input logic [31:0] wd,
                          input logic [3:0] be, output logic [31:0] rd, output logic e, output int lat);
    @(negedge clk);
    cpu_busy = 1; cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be; lat = 0;
    do begin @(negedge clk); lat++; end while (!cpu_ack && lat < 5000);
    rd = cpu_rdata; e = cpu_err;
    @(negedge clk);
    cpu_req = 0; cpu_busy = 0;
  endtask

  // shadow model of line state
  bit m_valid [NB], m_dirty [NB];
  logic [31:0] m_tag [NB];

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input string r);
    int idx, er, ew, r0, w0, lat;
    bit hit;
    logic [31:0] exp_d, rd;
    logic e;
    exp_d = g_rd(a); hit = 0; er = 0; ew = 0;
    if (a[31:28] == 4'hF) begin
      if (we) ew = 1; else er = 1;
    end else begin
      idx = int'((a >> 4) % NB);
      if (m_valid[idx] && m_tag[idx] == (a >> 4)) hit = 1;
      else begin
        er = WPL; ew = m_dirty[idx] ? WPL : 0;
        m_valid[idx] = 1; m_dirty[idx] = 0; m_tag[idx] = a >> 4;
      end
      if (we) m_dirty[idx] = 1;
    end
    if (we) gmem[int'(a[31:2])] = mrg(exp_d, wd, be);
    r0 = n_rd; w0 = n_wr;
    cpu_xfer(we, a, wd, be, rd, e, lat);
    if (!we) chk({r, " read data"}, rd, exp_d);
    chk({r, " no error"}, {31'b0, e}, 0);
    chk({r, " bus reads"}, 32'(n_rd - r0), 32'(er));
    chk({r, " bus writes"}, 32'(n_wr - w0), 32'(ew));
    if (hit) chk({r, " hit latency"}, 32'(lat), 1);
  endtask

  task automatic do_fence(input string r, output time t_done);
    int ew = 0, w0, c = 0, mism = 0;
    for (int i = 0; i < NB; i++) begin
      if (m_valid[i] && m_dirty[i]) ew += WPL;
      m_valid[i] = 0; m_dirty[i] = 0;
    end
    w0 = n_wr;
    @(negedge clk);
    fence_busy = 1; fence = 1;
    do begin @(negedge clk); c++; end while (!fence_done && c < 5000);
    t_done = $time;
    chk({r, " done raised"}, {31'b0, fence_done}, 1);
    @(negedge clk);
    fence = 0; fence_busy = 0;
    chk({r, " write-backs"}, 32'(n_wr - w0), 32'(ew));
    foreach (gmem[k]) if (s_rd({k[29:0], 2'b00}) !== gmem[k]) mism++;
    chk({r, " memory image after flush"}, 32'(mism), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] rd, lcg;
    logic e;
    int lat;
    time td, ta;
    for (int i = 0; i < NB; i++) begin m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ack low after reset", {31'b0, cpu_ack}, 0);
    chk("R1 bus idle after reset", {31'b0, bus_req}, 0);
    chk("R1 done low after reset", {31'b0, fence_done}, 0);

    baddr_q.delete();
    access(0, 32'h0000_0100, 0, 4'hF, "R1/R5 first read misses");
    for (int i = 0; i < WPL; i++) chk("R5 fill order", baddr_q[i], 32'h100 + 32'(4 * i));
    for (int i = 0; i < WPL; i++) chk("R5 fill byte enables", {28'b0, bbe_q[i]}, 32'hF);
    access(0, 32'h0000_0108, 0, 4'hF, "R3 read hit");
    access(1, 32'h0000_0104, 32'hAABB_CCDD, 4'b0011, "R4 write hit");
    access(0, 32'h0000_0104, 0, 4'hF, "R4 byte lanes merged");
    access(1, 32'h0000_0214, 32'h1234_5678, 4'b1111, "R6 write miss allocates");
    access(0, 32'h0000_0214, 0, 4'hF, "R6 allocated line holds write");

    baddr_q.delete();
    access(0, 32'h0000_0500, 0, 4'hF, "R2/R7 conflict on dirty line");
    for (int i = 0; i < WPL; i++) chk("R7 write-back order", baddr_q[i], 32'h100 + 32'(4 * i));
    for (int i = 0; i < WPL; i++) chk("R7 fill after write-back", baddr_q[WPL + i], 32'h500 + 32'(4 * i));
    chk("R7 old line in memory", s_rd(32'h104), mrg(seedv(32'h104), 32'hAABB_CCDD, 4'b0011));
    access(0, 32'h0000_0100, 0, 4'hF, "R2 evicted line misses again");

    baddr_q.delete(); bbe_q.delete();
    access(0, 32'hF000_0010, 0, 4'hF, "R8 uncached read");
    chk("R8 uncached read address", baddr_q[0], 32'hF000_0010);
    access(1, 32'hFFFF_FFF0, 32'h0102_0304, 4'b0101, "R8 uncached write");
    chk("R8 uncached write address", baddr_q[1], 32'hFFFF_FFF0);
    chk("R8 uncached byte enables", {28'b0, bbe_q[1]}, 32'h5);
    access(0, 32'h0000_0108, 0, 4'hF, "R8 cache state kept");
    access(0, 32'hFFFF_FFF0, 0, 4'hF, "R8 uncached not cached");

    do_fence("R9 fence", td);
    access(0, 32'h0000_0214, 0, 4'hF, "R9 reload after fence");

    access(1, 32'h0000_0330, 32'hCAFE_F00D, 4'hF, "R9 dirty before fence");
    fork
      do_fence("R9 fence with pending request", td);
      begin
        cpu_xfer(0, 32'h0000_0500, 0, 4'hF, rd, e, lat);
        ta = $time;
      end
    join
    chk("R9 request acknowledged after done", {31'b0, ta > td}, 1);
    chk("R9 pending read data", rd, g_rd(32'h500));
    m_valid[0] = 1; m_dirty[0] = 0; m_tag[0] = 32'h50;

    err_addr = 32'h0000_0624; err_arm = 1;
    cpu_xfer(0, 32'h0000_0620, 0, 4'hF, rd, e, lat);
    chk("R10 fill error reported", {31'b0, e}, 1);
    err_arm = 0;
    access(0, 32'h0000_0620, 0, 4'hF, "R10 line stayed invalid");
    err_addr = 32'hF000_0020; err_arm = 1;
    cpu_xfer(0, 32'hF000_0020, 0, 4'hF, rd, e, lat);
    chk("R10 uncached error reported", {31'b0, e}, 1);
    err_arm = 0;

    lcg = 32'h2468_ACE1;
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (lcg[31:29] == 3'd0) a = 32'hF000_0000 | {26'b0, lcg[11:8], 2'b00};
      else a = 32'(lcg[17:16] % 3) * 32'h1000 + {26'b0, lcg[13:12], lcg[9:8], 2'b00};
      access(lcg[20], a, lcg ^ 32'h5555_AAAA, lcg[27:24] | 4'b0001, "R2/R4/R5/R7 mixed traffic");
      if (n % 60 == 59) do_fence("R9 periodic fence", td);
    end
    do_fence("R9 final fence", td);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule